// File: doc/BRIEF.md
# Double to Extended-Range Single Narrowing Converter

This block narrows a 64-bit IEEE double-precision operand into a 32-bit single-precision word of an extended-range format. The result keeps the familiar single layout (sign, 8-bit biased exponent, 23-bit stored fraction with a hidden leading one). However, the all-ones exponent is an ordinary normal exponent, so the format has no infinity and no NaN encodings.

Values too large for the format saturate to the largest magnitude. Values below the smallest normal flush to positive zero. Extra fraction bits are always discarded, which is truncation toward zero. A valid strobe qualifies each operand. By default the result is registered one clock later. A parameter selects a purely combinational variant with zero latency.

Top module: `ers_narrow`

## Requirements
- R1: Input fields are sign [63], biased exponent [62:52] (bias 1023) and fraction [51:0]. Output fields are sign [31], biased exponent [30:23] (bias 127) and fraction [22:0]. For an in-range operand, the output exponent equals the input exponent minus 896 and the sign is copied.
- R2: For an in-range operand, the output fraction is the top 23 input fraction bits. The low 29 bits are dropped with no rounding up, for either sign.
- R3: An input exponent of 1151 gives output exponent 255 as an ordinary normal number, including the pattern 0x7F800000 and the largest magnitude 0x7FFFFFFF.
- R4: A finite input with an exponent above 1151 yields the input sign followed by 31 ones (0x7FFFFFFF or 0xFFFFFFFF).
- R5: An infinite input (exponent 2047, fraction zero) yields the input sign followed by 31 ones.
- R6: A NaN input (exponent 2047, fraction non-zero) yields 0x7FFFFFFF regardless of its sign.
- R7: A finite input with an exponent from 1 to 896 yields 0x00000000 regardless of sign. An output exponent of 0 never comes with a non-zero word, and exponent 897 gives the smallest normal 0x00800000.
- R8: Input zeros and input denormals (exponent 0) of either sign yield 0x00000000. The word 0x80000000 is never produced.
- R9: With registered output (REG_OUT=1), out_valid and out_data reflect the operand presented at the previous rising clock edge. An active-low reset clears both to zero.
- R10: With registered output, a cycle with in_valid low drives out_valid low on the next edge and leaves out_data unchanged, whatever in_data holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 32 | Extended-range single result |

## Verification
The bench builds two copies from the default field widths (11/52 in, 8/23 out). Instance u0 uses REG_OUT=1, and the second instance uses REG_OUT=0. Both share one stimulus, so each vector checks the combinational result before the clock edge and the registered result after it. The default widths place the saturation threshold at input exponent 1151 and the flush threshold at 896. This allows the vectors to land on both sides of each boundary, as well as on infinity, NaN, denormal and negative-zero encodings.

// File: rtl/ers_pkg.sv
package ers_pkg;

   // operand class found by the unpacker
   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NORM = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } ers_cls_e;

   // decision taken by the range stage
   typedef enum logic [1:0] {
      DEC_ZERO   = 2'd0,
      DEC_PASS   = 2'd1,
      DEC_SATSGN = 2'd2,
      DEC_SATPOS = 2'd3
   } ers_dec_e;

   function automatic int ers_bias(input int exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/ers_unpack.sv
module ers_unpack
   import ers_pkg::*;
#(
   parameter int IN_EXP_W  = 11,
   parameter int IN_FRAC_W = 52,
   localparam int IN_W     = 1 + IN_EXP_W + IN_FRAC_W
) (
   input  logic [IN_W-1:0]      word_i,
   output logic                 sign_o,
   output logic [IN_EXP_W-1:0]  exp_o,
   output logic [IN_FRAC_W-1:0] frac_o,
   output ers_cls_e             cls_o
);

   localparam logic [IN_EXP_W-1:0] EXP_ONES = '1;

   always_comb begin
      sign_o = word_i[IN_W-1];
      exp_o  = word_i[IN_W-2 -: IN_EXP_W];
      frac_o = word_i[IN_FRAC_W-1:0];
      if (exp_o == '0) begin
         cls_o = CLS_ZERO;           // zero or denormal, both flushed
      end else if (exp_o == EXP_ONES) begin
         cls_o = (frac_o == '0) ? CLS_INF : CLS_NAN;
      end else begin
         cls_o = CLS_NORM;
      end
   end

endmodule

// File: rtl/ers_range.sv
module ers_range
   import ers_pkg::*;
#(
   parameter int IN_EXP_W  = 11,
   parameter int OUT_EXP_W = 8
) (
   input  logic [IN_EXP_W-1:0]  exp_i,
   input  ers_cls_e             cls_i,
   output ers_dec_e             dec_o,
   output logic [OUT_EXP_W-1:0] exp_o
);

   localparam int IN_BIAS  = ers_bias(IN_EXP_W);
   localparam int OUT_BIAS = ers_bias(OUT_EXP_W);
   localparam int SHIFT    = IN_BIAS - OUT_BIAS;
   localparam int LO_EXP   = SHIFT + 1;
   localparam int HI_EXP   = SHIFT + (1 << OUT_EXP_W) - 1;

   localparam logic [IN_EXP_W-1:0] SHIFT_E = IN_EXP_W'(SHIFT);
   localparam logic [IN_EXP_W-1:0] LO_E    = IN_EXP_W'(LO_EXP);
   localparam logic [IN_EXP_W-1:0] HI_E    = IN_EXP_W'(HI_EXP);

   logic [IN_EXP_W-1:0] rebased;

   always_comb begin
      rebased = exp_i - SHIFT_E;
      exp_o   = rebased[OUT_EXP_W-1:0];
      unique case (cls_i)
         CLS_ZERO: dec_o = DEC_ZERO;
         CLS_INF:  dec_o = DEC_SATSGN;
         CLS_NAN:  dec_o = DEC_SATPOS;
         default: begin
            if (exp_i > HI_E)      dec_o = DEC_SATSGN;
            else if (exp_i < LO_E) dec_o = DEC_ZERO;
            else                   dec_o = DEC_PASS;
         end
      endcase
   end

endmodule

// File: rtl/ers_pack.sv
module ers_pack
   import ers_pkg::*;
#(
   parameter int OUT_EXP_W  = 8,
   parameter int OUT_FRAC_W = 23,
   parameter int IN_FRAC_W  = 52,
   localparam int OUT_W     = 1 + OUT_EXP_W + OUT_FRAC_W
) (
   input  logic                  sign_i,
   input  ers_dec_e              dec_i,
   input  logic [OUT_EXP_W-1:0]  exp_i,
   input  logic [IN_FRAC_W-1:0]  frac_i,
   output logic [OUT_W-1:0]      word_o
);

   localparam logic [OUT_W-2:0] MAG_MAX = '1;

   logic [OUT_FRAC_W-1:0] kept;

   always_comb begin
      kept = frac_i[IN_FRAC_W-1 -: OUT_FRAC_W];   // truncation toward zero
      unique case (dec_i)
         DEC_PASS:   word_o = {sign_i, exp_i, kept};
         DEC_SATSGN: word_o = {sign_i, MAG_MAX};
         DEC_SATPOS: word_o = {1'b0, MAG_MAX};
         default:    word_o = '0;                  // always positive zero
      endcase
   end

endmodule

// File: rtl/ers_stage.sv
module ers_stage #(
   parameter int W       = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_i,
   input  logic [W-1:0] dat_i,
   output logic         vld_o,
   output logic [W-1:0] dat_o
);

   generate
      if (REG_OUT) begin : g_reg
         logic         vld_q;
         logic [W-1:0] dat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else begin
               vld_q <= vld_i;
               if (vld_i) dat_q <= dat_i;
            end
         end
         assign vld_o = vld_q;
         assign dat_o = dat_q;

         assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> vld_o);
         assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_i |=> (!vld_o && $stable(dat_o)));
      end else begin : g_comb
         assign vld_o = vld_i;
         assign dat_o = dat_i;
      end
   endgenerate

endmodule

// File: rtl/ers_narrow.sv
module ers_narrow
   import ers_pkg::*;
#(
   parameter int IN_EXP_W   = 11,
   parameter int IN_FRAC_W  = 52,
   parameter int OUT_EXP_W  = 8,
   parameter int OUT_FRAC_W = 23,
   parameter bit REG_OUT    = 1'b1,
   localparam int IN_W      = 1 + IN_EXP_W + IN_FRAC_W,
   localparam int OUT_W     = 1 + OUT_EXP_W + OUT_FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);

   generate
      if (OUT_FRAC_W > IN_FRAC_W) begin : g_bad_frac
         $error("ers_narrow: output fraction wider than input fraction");
      end
      if (OUT_EXP_W >= IN_EXP_W) begin : g_bad_exp
         $error("ers_narrow: output exponent must be narrower than input");
      end
      if (OUT_EXP_W < 2 || OUT_FRAC_W < 1) begin : g_bad_small
         $error("ers_narrow: output fields too small");
      end
   endgenerate

   localparam logic [OUT_W-2:0] MAG_MAX = '1;

   logic                  u_sign;
   logic [IN_EXP_W-1:0]   u_exp;
   logic [IN_FRAC_W-1:0]  u_frac;
   ers_cls_e              u_cls;
   ers_dec_e              r_dec;
   logic [OUT_EXP_W-1:0]  r_exp;
   logic [OUT_W-1:0]      p_word;

   ers_unpack #(.IN_EXP_W(IN_EXP_W), .IN_FRAC_W(IN_FRAC_W)) u_unpack (
      .word_i (in_data),
      .sign_o (u_sign),
      .exp_o  (u_exp),
      .frac_o (u_frac),
      .cls_o  (u_cls)
   );

   ers_range #(.IN_EXP_W(IN_EXP_W), .OUT_EXP_W(OUT_EXP_W)) u_range (
      .exp_i (u_exp),
      .cls_i (u_cls),
      .dec_o (r_dec),
      .exp_o (r_exp)
   );

   ers_pack #(.OUT_EXP_W(OUT_EXP_W), .OUT_FRAC_W(OUT_FRAC_W),
              .IN_FRAC_W(IN_FRAC_W)) u_pack (
      .sign_i (u_sign),
      .dec_i  (r_dec),
      .exp_i  (r_exp),
      .frac_i (u_frac),
      .word_o (p_word)
   );

   ers_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .dat_i (p_word),
      .vld_o (out_valid),
      .dat_o (out_data)
   );

   // infinity operand reaches the packed word as signed maximum
   assert_inf_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && u_cls == CLS_INF) |-> (p_word == {u_sign, MAG_MAX}));
   // NaN operand reaches the packed word as positive maximum
   assert_nan_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && u_cls == CLS_NAN) |-> (p_word == {1'b0, MAG_MAX}));
   // a zero exponent in the result only with an all-zero word
   assert_no_denorm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_data[OUT_W-2 -: OUT_EXP_W] == '0) |-> (out_data == '0));
   // negative zero is never produced
   assert_no_negzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data != {1'b1, {(OUT_W-1){1'b0}}}));

endmodule

// File: tb/sim_ers_narrow.sv
`timescale 1ns/1ps
module sim_ers_narrow;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        out_valid, c_valid;
   logic [31:0] out_data, c_data;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;   // 50 MHz

   ers_narrow #(.REG_OUT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   ers_narrow #(.REG_OUT(1'b0)) u_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(c_valid), .out_data(c_data));

   // {requirement number, operand, expected result}
   localparam int NV = 20;
   localparam logic [103:0] VEC [NV] = '{
      {8'd1,  64'h3FF0_0000_0000_0000, 32'h3F80_0000},   // R1  1.0
      {8'd1,  64'hC004_0000_0000_0000, 32'hC020_0000},   // R1  -2.5
      {8'd1,  64'h4059_0000_0000_0000, 32'h42C8_0000},   // R1  100.0
      {8'd2,  64'h3FFF_FFFF_FFFF_FFFF, 32'h3FFF_FFFF},   // R2  no round-up
      {8'd2,  64'hBFFF_FFFF_FFFF_FFFF, 32'hBFFF_FFFF},   // R2  negative
      {8'd2,  64'h3FF0_0000_1FFF_FFFF, 32'h3F80_0000},   // R2  dropped bits only
      {8'd3,  64'h47FF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF},   // R3  largest
      {8'd3,  64'h47F0_0000_0000_0000, 32'h7F80_0000},   // R3  not infinity
      {8'd4,  64'h4800_0000_0000_0000, 32'h7FFF_FFFF},   // R4  just over
      {8'd4,  64'hFFE0_0000_0000_0000, 32'hFFFF_FFFF},   // R4  negative huge
      {8'd5,  64'h7FF0_0000_0000_0000, 32'h7FFF_FFFF},   // R5  +inf
      {8'd5,  64'hFFF0_0000_0000_0000, 32'hFFFF_FFFF},   // R5  -inf
      {8'd6,  64'h7FF8_0000_0000_0000, 32'h7FFF_FFFF},   // R6  quiet NaN
      {8'd6,  64'hFFF0_0000_0000_0001, 32'h7FFF_FFFF},   // R6  negative NaN
      {8'd7,  64'h3810_0000_0000_0000, 32'h0080_0000},   // R7  smallest normal
      {8'd7,  64'h380F_FFFF_FFFF_FFFF, 32'h0000_0000},   // R7  just under
      {8'd7,  64'hB80F_FFFF_FFFF_FFFF, 32'h0000_0000},   // R7  negative tiny
      {8'd8,  64'h0000_0000_0000_0000, 32'h0000_0000},   // R8  +0
      {8'd8,  64'h8000_0000_0000_0000, 32'h0000_0000},   // R8  -0
      {8'd8,  64'h800F_FFFF_FFFF_FFFF, 32'h0000_0000}    // R8  denormal
   };

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] last;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 reset valid", {31'd0, out_valid}, 32'd0);
      check("R9 reset data", out_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle after reset", {31'd0, out_valid}, 32'd0);

      last = '0;
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][103:96], i);
         in_valid = 1'b1;
         in_data  = VEC[i][95:32];
         #1;
         check({tag, " comb"}, c_data, VEC[i][31:0]);
         @(posedge clk);
         @(negedge clk);
         check({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
         check({tag, " reg"}, out_data, VEC[i][31:0]);
         last = VEC[i][31:0];
      end

      // R10: idle cycle with a live-looking operand must not disturb output
      in_valid = 1'b0;
      in_data  = 64'h3FF0_0000_0000_0000;
      @(posedge clk);
      @(negedge clk);
      check("R10 valid low", {31'd0, out_valid}, 32'd0);
      check("R10 data held", out_data, last);
      in_data = 64'hC004_0000_0000_0000;
      @(posedge clk);
      @(negedge clk);
      check("R10 data still held", out_data, last);

      // R9: one-cycle latency, output changes only after the edge
      in_valid = 1'b1;
      in_data  = 64'h4059_0000_0000_0000;
      #1;
      check("R9 before edge", out_data, last);
      @(posedge clk);
      @(negedge clk);
      check("R9 after edge", out_data, 32'h42C8_0000);

      // R9: reset mid-run clears registered output
      rst_n = 1'b0;
      #1;
      check("R9 async reset valid", {31'd0, out_valid}, 32'd0);
      check("R9 async reset data", out_data, 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule